// File: doc/BRIEF.md
# Cascadable Priority Request Encoder

This block turns a set of request lines into the index of the most important pending request. Each encoder unit watches eight active-low request lines and reports the winner as an active-low three-bit code. It also raises two active-low flags. One says that the unit is enabled and holds at least one request. The other says that the unit is enabled but idle. A unit whose active-low enable is released drives every output high.

The top module joins two such units into a sixteen-request encoder. The idle flag of the upper unit enables the lower unit, so the lower half only speaks when the upper half is silent. The hit flag of the upper unit provides the most significant code bit. The remaining code bits are the AND of both units' active-low codes. The whole path is combinational: the result follows the request lines with no clock. Because there is no data flow, there are no valid/ready handshakes. Every pin is plain control and status.

Top module: `prienc_cascade16`

## Requirements
- R1: Among active requests (request pin at 0), the one with the highest index wins. Any active request with a lower index has no effect on the outputs.
- R2: When the enable input is 1, every code bit, the hit flag and the idle flag are all 1, whatever the requests are.
- R3: When enabled with a winner, the code output is the bitwise complement of the winner's index. In a unit, request 7 alone gives 000 and request 0 alone gives 111.
- R4: The hit flag is 0 exactly when the enable is 0 and at least one request is 0.
- R5: The idle flag is 0 exactly when the enable is 0 and no request is 0. In that case every code bit and the hit flag are 1.
- R6: In the sixteen-request top, the upper unit serves requests 15..8 and the lower unit serves requests 7..0. The four-bit code is the complement of the overall highest active index. Code bit 3 equals the upper unit's hit flag.
- R7: The top's idle flag is 0 only when the top is enabled and all sixteen requests are 1. The lower unit is enabled only when the upper unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_in_n | input | 1 | Active-low enable for the chain |
| req_n | input | 16 | Active-low request lines; bit 15 has the highest priority |
| code_n | output | 4 | Active-low index of the winning request |
| hit_n | output | 1 | 0 when enabled with at least one request |
| pass_n | output | 1 | 0 when enabled with no request; this drives the next stage's enable |

## Verification
Two things can happen in the same cycle. Priority resolution among several active requests can coincide with the enable being released. Likewise, an upper-half request can hide a simultaneous lower-half request through the enable chain. Both are provoked by sweeping every request pattern once with the enable asserted and once with it released. This is done for a single unit (256 patterns) and for the full sixteen-request top (65536 patterns). Each cycle is judged against a behavioural scan from the top index downward. That scan must show the enable overriding everything, and the upper winner masking every lower request.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  // Default number of request lines per encoder unit.
  localparam int unsigned UNIT_REQS = 8;
  // Number of units joined in the top-level chain.
  localparam int unsigned CHAIN_LEN = 2;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  // Scan from low to high so that a higher active index overwrites a lower one.
  always_comb begin
    idx = '0;
    any = |req;
    for (int k = 0; k < N; k++) begin
      if (req[k]) idx = W'(k);
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned W = 3
) (
  input  logic         en_n,
  input  logic         any,
  input  logic [W-1:0] idx,
  output logic [W-1:0] code_n,
  output logic         hit_n,
  output logic         pass_n
);
  logic live;

  always_comb begin
    live   = !en_n && any;
    code_n = live ? ~idx : '1;
    hit_n  = !live;
    pass_n = en_n || any;
  end
endmodule

// File: rtl/prienc_unit.sv
module prienc_unit #(
  parameter int unsigned N = prienc_pkg::UNIT_REQS,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         en_n,
  input  logic [N-1:0] req_n,
  output logic [W-1:0] code_n,
  output logic         hit_n,
  output logic         pass_n
);
  logic [N-1:0] req;
  logic [W-1:0] idx;
  logic         any;

  assign req = ~req_n;

  prio_pick #(.N(N)) u_pick (
    .req (req),
    .idx (idx),
    .any (any)
  );

  out_stage #(.W(W)) u_out (
    .en_n   (en_n),
    .any    (any),
    .idx    (idx),
    .code_n (code_n),
    .hit_n  (hit_n),
    .pass_n (pass_n)
  );

  logic [W-1:0] win;
  logic         above_busy;

  always_comb begin
    win        = ~code_n;
    above_busy = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (k > int'(win) && !req_n[k]) above_busy = 1'b1;
    end
    // R2
    if (en_n) begin
      r2_off_chk: assert (code_n == '1 && hit_n && pass_n)
        else $error("unit outputs not parked while disabled");
    end
    // R5
    if (!pass_n) begin
      r5_idle_chk: assert (hit_n && code_n == '1 && req_n == '1)
        else $error("idle flag with pending request");
    end
    // R1
    if (!hit_n) begin
      r1_win_chk: assert (!req_n[win] && !above_busy)
        else $error("reported winner is not the top request");
    end
  end
endmodule

// File: rtl/prienc_cascade16.sv
module prienc_cascade16 #(
  parameter int unsigned UNIT_N = prienc_pkg::UNIT_REQS,
  localparam int unsigned UNITS  = prienc_pkg::CHAIN_LEN,
  localparam int unsigned TOTAL  = UNITS * UNIT_N,
  localparam int unsigned UW     = $clog2(UNIT_N)
) (
  input  logic             en_in_n,
  input  logic [TOTAL-1:0] req_n,
  output logic [UW:0]      code_n,
  output logic             hit_n,
  output logic             pass_n
);
  logic [UNITS:0]  en_chain;
  logic [UW-1:0]   u_code [UNITS];
  logic [UNITS-1:0] u_hit;

  assign en_chain[UNITS] = en_in_n;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    prienc_unit #(.N(UNIT_N)) u_enc (
      .en_n   (en_chain[u+1]),
      .req_n  (req_n[u*UNIT_N +: UNIT_N]),
      .code_n (u_code[u]),
      .hit_n  (u_hit[u]),
      .pass_n (en_chain[u])
    );
  end

  assign code_n[UW]     = u_hit[1];
  assign code_n[UW-1:0] = u_code[1] & u_code[0];
  assign hit_n          = &u_hit;
  assign pass_n         = en_chain[0];

  logic [UW:0] top_win;

  always_comb begin
    top_win = ~code_n;
    // R7
    if (!pass_n) begin
      r7_chain_chk: assert (!en_in_n && req_n == '1)
        else $error("chain idle flag with pending request");
    end
    // R6
    if (!hit_n) begin
      r6_top_chk: assert (!req_n[top_win] && pass_n)
        else $error("chain winner not an active request");
    end
  end
endmodule

// File: tb/prienc_cascade16_bench.sv
module prienc_cascade16_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        en_in_n = 1'b1;
  logic [15:0] req_n   = '1;
  logic [3:0]  code_n;
  logic        hit_n, pass_n;

  logic        u_en_n = 1'b1;
  logic [7:0]  u_req_n = '1;
  logic [2:0]  u_code_n;
  logic        u_hit_n, u_pass_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  prienc_cascade16 u_prienc_cascade16 (
    .en_in_n (en_in_n),
    .req_n   (req_n),
    .code_n  (code_n),
    .hit_n   (hit_n),
    .pass_n  (pass_n)
  );

  prienc_unit #(.N(8)) u_single (
    .en_n   (u_en_n),
    .req_n  (u_req_n),
    .code_n (u_code_n),
    .hit_n  (u_hit_n),
    .pass_n (u_pass_n)
  );

  function automatic int top_active(input logic [15:0] r_n, input int n);
    for (int k = n - 1; k >= 0; k--) if (!r_n[k]) return k;
    return -1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d en=%0b req=%h", tag, act, exp, en_in_n, req_n);
    end
  endtask

  task automatic check_unit();
    int w;
    w = top_active({8'hFF, u_req_n}, 8);
    if (u_en_n) begin
      check("R2 unit code", u_code_n, 7);
      check("R2 unit hit", u_hit_n, 1);
      check("R2 unit idle", u_pass_n, 1);
    end else if (w < 0) begin
      check("R5 unit code", u_code_n, 7);
      check("R5 unit hit", u_hit_n, 1);
      check("R5 unit idle", u_pass_n, 0);
    end else begin
      check("R1 R3 unit code", u_code_n, 7 - w);
      check("R4 unit hit", u_hit_n, 0);
      check("R5 unit idle busy", u_pass_n, 1);
    end
  endtask

  task automatic check_top();
    int w;
    w = top_active(req_n, 16);
    if (en_in_n) begin
      check("R2 top code", code_n, 15);
      check("R2 top hit", hit_n, 1);
      check("R7 top idle off", pass_n, 1);
    end else if (w < 0) begin
      check("R6 top code idle", code_n, 15);
      check("R4 top hit idle", hit_n, 1);
      check("R7 top idle", pass_n, 0);
    end else begin
      check("R6 top code", code_n, 15 - w);
      check("R6 top msb", code_n[3], (w >= 8) ? 0 : 1);
      check("R4 top hit", hit_n, 0);
      check("R7 top idle busy", pass_n, 1);
    end
  endtask

  initial begin
    // Start state: everything released.
    @(negedge clk);
    check("R2 start code", code_n, 15);
    check("R2 start idle", pass_n, 1);
    // R3 directed: single requests on a unit.
    @(posedge clk); u_en_n = 0; u_req_n = 8'h7F;
    @(negedge clk); check("R3 req7 alone", u_code_n, 0);
    @(posedge clk); u_req_n = 8'hFE;
    @(negedge clk); check("R3 req0 alone", u_code_n, 7);
    // R1 directed: low request added under a high one.
    @(posedge clk); u_req_n = 8'hDA;
    @(negedge clk); check("R1 lower ignored", u_code_n, 2);
    // Unit sweep, both enable values.
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        @(posedge clk); u_en_n = e[0]; u_req_n = p[7:0];
        @(negedge clk); check_unit();
      end
    end
    // Cascade sweep, both enable values.
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 65536; p++) begin
        @(posedge clk); en_in_n = e[0]; req_n = p[15:0];
        @(negedge clk); check_top();
      end
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule